// File: doc/BRIEF.md
# Mixed-Edge Scan Chain with Domain Lockup Latches

This block is a serial scan path built from multiplexed scan flip-flops and driven by two test clocks. While `scan_en` is low, one test clock pulse makes every flop load its functional data bit. While `scan_en` is high, every flop instead loads the bit held by the stage before it, so a pattern fed in at `scan_in` moves one position per pulse and leaves the chain at `scan_out`.

The chain has three groups, always in the same order. Falling-edge flops on clock A come first. Rising-edge flops on clock A follow them. Rising-edge flops on clock B come last. A falling-edge flop is a rising-edge storage cell with its clock inverted, so edge sense is fixed by the clock path and not by the cell type. Because the falling group leads, no rising-edge flop ever feeds a falling-edge flop, and the single fall-to-rise boundary needs no latch.

Where the chain passes from clock A to clock B, a level-sensitive lockup latch is open while clock A is low. This lets clock B arrive late by up to half a period without losing a bit. A second lockup latch, open while clock B is low, can be fitted at the tail so that chains can be joined one after another. Both test clocks are positive pulses: they idle low, rise, then fall.

Top module: `mixed_scan_chain`

## Requirements
- R1: While `rst_n` is low, every flop output `q` and `scan_out` are 0, asynchronously.
- R2: With `scan_en` low, one clock pulse makes `q[i]` equal to `func_d[i]` for every chain position i.
- R3: With `scan_en` high, after pulse k (counting from 1), `q[i]` holds the `scan_in` bit presented before pulse k-i. A pattern entered LSB first therefore appears bit for bit at `scan_out`, starting after pulse N, where N = NEG_CNT+POS_CNT+B_CNT. The tail latch adds no extra pulse.
- R4: Positions 0..NEG_CNT-1 update on the falling edge of `clk_a`. Positions NEG_CNT..NEG_CNT+POS_CNT-1 update on the rising edge of `clk_a`. The remaining positions update on the rising edge of `clk_b`.
- R5: When `clk_b` lags `clk_a` by less than half a period, the first clock-B flop receives, on each shift pulse, the value the last clock-A flop held before that pulse. No bit is lost or duplicated at the crossing.
- R6: With TAIL_LATCH=1, `scan_out` keeps its old value while `clk_b` is high and takes the new last-flop value only after `clk_b` falls. With TAIL_LATCH=0, `scan_out` follows the last flop right after the `clk_b` rising edge.
- R7: After a capture pulse, `scan_out` presents `func_d[N-1]`. Each further shift pulse j then presents `func_d[N-1-j]`.
- R8: `func_d` has no effect while `scan_en` is high, and `scan_in` has no effect while `scan_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Test clock of the falling and rising groups, positive pulse |
| clk_b | input | 1 | Test clock of the second-domain group, positive pulse |
| rst_n | input | 1 | Active-low asynchronous reset of all flops and latches |
| scan_en | input | 1 | 1 = shift from previous stage, 0 = capture functional data |
| scan_in | input | 1 | Serial input to chain position 0 |
| func_d | input | N | Functional data, bit i feeds chain position i |
| q | output | N | Flop outputs, bit i is chain position i |
| scan_out | output | 1 | Serial output after the last flop, through the tail latch if fitted |

## Verification
The hardest situation to reach is the crossing itself. The last clock-A flop has already changed by the time clock B rises, and only the lockup latch keeps the old bit alive. The bench therefore skews `clk_b` a quarter period behind `clk_a` on every pulse. It samples the chain between the clock-A rise and the clock-B rise, between the clock-A fall and the clock-B fall, and at pulse end. At each point it compares every position with a value computed from the input stream index. This sampling also exposes a group clocked on the wrong edge and a tail latch open in the wrong phase. A second instance without the tail latch runs in lock step, so the half-period difference in when `scan_out` changes is measured directly.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;

  function automatic int chain_len(input int n_fall, input int n_rise, input int n_far);
    return n_fall + n_rise + n_far;
  endfunction

endpackage

// File: rtl/scan_cell.sv
module scan_cell
  import scan_pkg::*;
#(
  parameter edge_e EDGE = EDGE_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic se,
  input  logic si,
  input  logic fd,
  output logic q
);
  // Edge sense comes from the clock path: an inverted clock turns the
  // rising-edge storage element into a falling-edge activated one.
  logic ck;
  assign ck = (EDGE == EDGE_FALL) ? ~clk : clk;

  always_ff @(posedge ck or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= se ? si : fd;
  end
endmodule

// File: rtl/lockup_latch.sv
module lockup_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  // Open during the low phase of clk: the launched bit is held through the
  // high phase, so a late-arriving downstream edge still sees the old value.
  always_latch begin
    if (!rst_n)   q = 1'b0;
    else if (!clk) q = d;
  end
endmodule

// File: rtl/scan_segment.sv
module scan_segment
  import scan_pkg::*;
#(
  parameter int    WIDTH = 2,
  parameter edge_e EDGE  = EDGE_RISE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             se,
  input  logic             si,
  input  logic [WIDTH-1:0] fd,
  output logic [WIDTH-1:0] q,
  output logic             so
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic sin;
    if (i == 0) begin : g_head
      assign sin = si;
    end else begin : g_link
      assign sin = q[i-1];
    end
    scan_cell #(.EDGE(EDGE)) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .se   (se),
      .si   (sin),
      .fd   (fd[i]),
      .q    (q[i])
    );
  end

  assign so = q[WIDTH-1];
endmodule

// File: rtl/mixed_scan_chain.sv
module mixed_scan_chain
  import scan_pkg::*;
#(
  parameter int NEG_CNT    = 2,
  parameter int POS_CNT    = 3,
  parameter int B_CNT      = 3,
  parameter bit TAIL_LATCH = 1'b1,
  localparam int N         = chain_len(NEG_CNT, POS_CNT, B_CNT),
  localparam int A_CNT     = NEG_CNT + POS_CNT
) (
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         rst_n,
  input  logic         scan_en,
  input  logic         scan_in,
  input  logic [N-1:0] func_d,
  output logic [N-1:0] q,
  output logic         scan_out
);
  logic [NEG_CNT-1:0] neg_q;
  logic [POS_CNT-1:0] pos_q;
  logic [B_CNT-1:0]   far_q;
  logic neg_so, pos_so, cross_q, far_so;

  // Falling group leads, so the only edge change in domain A is fall -> rise.
  scan_segment #(.WIDTH(NEG_CNT), .EDGE(EDGE_FALL)) u_seg_fall (
    .clk(clk_a), .rst_n(rst_n), .se(scan_en), .si(scan_in),
    .fd(func_d[NEG_CNT-1:0]), .q(neg_q), .so(neg_so)
  );

  scan_segment #(.WIDTH(POS_CNT), .EDGE(EDGE_RISE)) u_seg_rise (
    .clk(clk_a), .rst_n(rst_n), .se(scan_en), .si(neg_so),
    .fd(func_d[A_CNT-1:NEG_CNT]), .q(pos_q), .so(pos_so)
  );

  // Domain crossing A -> B.
  lockup_latch u_cross_latch (
    .clk(clk_a), .rst_n(rst_n), .d(pos_so), .q(cross_q)
  );

  scan_segment #(.WIDTH(B_CNT), .EDGE(EDGE_RISE)) u_seg_far (
    .clk(clk_b), .rst_n(rst_n), .se(scan_en), .si(cross_q),
    .fd(func_d[N-1:A_CNT]), .q(far_q), .so(far_so)
  );

  if (TAIL_LATCH) begin : g_tail
    lockup_latch u_tail_latch (
      .clk(clk_b), .rst_n(rst_n), .d(far_so), .q(scan_out)
    );
  end else begin : g_no_tail
    assign scan_out = far_so;
  end

  assign q = {far_q, pos_q, neg_q};
endmodule

// File: rtl/mixed_scan_chain_chk.sv
module mixed_scan_chain_chk #(
  parameter int NEG_CNT    = 2,
  parameter int POS_CNT    = 3,
  parameter int B_CNT      = 3,
  parameter bit TAIL_LATCH = 1'b1,
  localparam int N         = NEG_CNT + POS_CNT + B_CNT,
  localparam int A_CNT     = NEG_CNT + POS_CNT
) (
  input logic         clk_a,
  input logic         clk_b,
  input logic         rst_n,
  input logic         scan_en,
  input logic [N-1:0] func_d,
  input logic [N-1:0] q,
  input logic         scan_out
);
  if (NEG_CNT >= 2) begin : g_neg_shift
    // R4
    neg_shift_chk: assert property (@(negedge clk_a) disable iff (!rst_n)
      scan_en |=> q[NEG_CNT-1:1] == $past(q[NEG_CNT-2:0]));
  end

  // R4
  fall_to_rise_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
    scan_en |=> q[NEG_CNT] == $past(q[NEG_CNT-1]));

  if (POS_CNT >= 2) begin : g_pos_shift
    // R3
    rise_shift_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
      scan_en |=> q[A_CNT-1:NEG_CNT+1] == $past(q[A_CNT-2:NEG_CNT]));
  end

  if (B_CNT >= 2) begin : g_far_shift
    // R3
    far_shift_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
      scan_en |=> q[N-1:A_CNT+1] == $past(q[N-2:A_CNT]));
  end

  // R5
  crossing_hold_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
    scan_en |=> q[A_CNT] == $past(q[A_CNT-1], 2));

  // R2
  capture_rise_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
    !scan_en |=> q[A_CNT-1:NEG_CNT] == $past(func_d[A_CNT-1:NEG_CNT]));

  // R2
  capture_fall_chk: assert property (@(negedge clk_a) disable iff (!rst_n)
    !scan_en |=> q[NEG_CNT-1:0] == $past(func_d[NEG_CNT-1:0]));

  // R2
  capture_far_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
    !scan_en |=> q[N-1:A_CNT] == $past(func_d[N-1:A_CNT]));

  if (TAIL_LATCH) begin : g_tail_chk
    // R6
    tail_delay_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
      scan_out == q[N-1]);
  end
endmodule

bind mixed_scan_chain mixed_scan_chain_chk #(
  .NEG_CNT(NEG_CNT), .POS_CNT(POS_CNT), .B_CNT(B_CNT), .TAIL_LATCH(TAIL_LATCH)
) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .scan_en(scan_en),
  .func_d(func_d), .q(q), .scan_out(scan_out)
);

// File: tb/mixed_scan_chain_tb.sv
`timescale 1ns/1ps
module mixed_scan_chain_tb;
  localparam int NEG = 2;
  localparam int POS = 3;
  localparam int FAR = 3;
  localparam int N   = NEG + POS + FAR;
  localparam int NPAT = 256;
  localparam int SLEN = NPAT * N;
  localparam logic [N-1:0] NEG_M = (N'(1) << NEG) - N'(1);
  localparam logic [N-1:0] POS_M = ((N'(1) << (NEG + POS)) - N'(1)) & ~NEG_M;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic scan_en = 1'b0, scan_in = 1'b0;
  logic [N-1:0] func_d = '0;
  logic [N-1:0] q, q_nt;
  logic so, so_nt;

  logic [N-1:0] s_ar_q, s_br_q, s_af_q;
  logic s_br_so, s_br_so_nt;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  mixed_scan_chain #(.NEG_CNT(NEG), .POS_CNT(POS), .B_CNT(FAR), .TAIL_LATCH(1'b1)) u_dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .scan_en(scan_en),
    .scan_in(scan_in), .func_d(func_d), .q(q), .scan_out(so)
  );

  mixed_scan_chain #(.NEG_CNT(NEG), .POS_CNT(POS), .B_CNT(FAR), .TAIL_LATCH(1'b0)) u_dut_notail (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .scan_en(scan_en),
    .scan_in(scan_in), .func_d(func_d), .q(q_nt), .scan_out(so_nt)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One 4 ns pulse; clk_b lags clk_a by 1 ns (less than half a period).
  task automatic pulse();
    #0.5 clk_a = 1'b1;
    #0.5 s_ar_q = q;
    #0.5 clk_b = 1'b1;
    #0.5 begin s_br_q = q; s_br_so = so; s_br_so_nt = so_nt; end
    #0.5 clk_a = 1'b0;
    #0.5 s_af_q = q;
    #0.5 clk_b = 1'b0;
    #0.5;
  endtask

  // Bit m of the serial stream: pattern m/N, bit m%N, LSB first.
  function automatic logic sbit(input int m);
    logic [N-1:0] p;
    if (m < 0 || m >= SLEN) return 1'b0;
    p = N'(m / N);
    return p[m % N];
  endfunction

  function automatic logic [N-1:0] exp_q(input int k);
    logic [N-1:0] e;
    for (int i = 0; i < N; i++) e[i] = sbit(k - 1 - i);
    return e;
  endfunction

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] e_now, e_prev;
    #2;
    // R1 reset state
    chk("R1 q at reset", 64'(q), 64'(0));
    chk("R1 scan_out at reset", 64'(so), 64'(0));
    chk("R1 notail scan_out at reset", 64'(so_nt), 64'(0));
    rst_n = 1'b1;
    #2;

    // R3 R4 R5 R6 R8: stream every 8-bit pattern back to back
    scan_en = 1'b1;
    for (int k = 1; k <= SLEN + N; k++) begin
      scan_in = sbit(k - 1);
      func_d  = N'(k * 37 + 5);   // ignored while shifting (R8)
      pulse();
      e_now  = exp_q(k);
      e_prev = exp_q(k - 1);
      chk("R4 after clk_a rise", 64'(s_ar_q), 64'((e_now & POS_M) | (e_prev & ~POS_M)));
      chk("R5 after clk_b rise", 64'(s_br_q), 64'((e_now & ~NEG_M) | (e_prev & NEG_M)));
      chk("R4 after clk_a fall", 64'(s_af_q), 64'(e_now));
      chk("R3 R8 q at pulse end", 64'(q), 64'(e_now));
      chk("R3 scan_out", 64'(so), 64'(sbit(k - N)));
      chk("R6 tail holds while clk_b high", 64'(s_br_so), 64'(sbit(k - 1 - N)));
      chk("R6 notail follows after clk_b rise", 64'(s_br_so_nt), 64'(sbit(k - N)));
      chk("R3 notail scan_out", 64'(so_nt), 64'(sbit(k - N)));
    end

    // R2 R7 R8: capture every functional pattern, then unload it
    for (int p = 0; p < NPAT; p++) begin
      scan_en = 1'b0;
      func_d  = N'(p);
      scan_in = ~func_d[0];        // ignored while capturing (R8)
      pulse();
      chk("R2 R8 captured q", 64'(q), 64'(p));
      chk("R2 notail captured q", 64'(q_nt), 64'(p));
      chk("R7 first unload bit", 64'(so), 64'(func_d[N-1]));
      scan_en = 1'b1;
      scan_in = 1'b0;
      for (int j = 1; j < N; j++) begin
        func_d = ~N'(p);           // ignored while shifting (R8)
        pulse();
        chk("R7 unload bit", 64'(so), 64'((p >> (N - 1 - j)) & 1));
        chk("R7 notail unload bit", 64'(so_nt), 64'((p >> (N - 1 - j)) & 1));
      end
    end

    // R1: asynchronous clear of a loaded chain
    scan_en = 1'b0;
    func_d  = N'(8'hA5);
    pulse();
    chk("R2 load before reset", 64'(q), 64'(8'hA5));
    #1 rst_n = 1'b0;
    #1;
    chk("R1 async clear q", 64'(q), 64'(0));
    chk("R1 async clear scan_out", 64'(so), 64'(0));
    chk("R1 async clear notail q", 64'(q_nt), 64'(0));
    #1 rst_n = 1'b1;
    #2;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule